// File: doc/BRIEF.md
# Multiplexed-Address Asynchronous DRAM Sequencer

This block is the engine between a simple byte request port and an asynchronous DRAM module. The DRAM module has a shared row/column address bus, active-low row strobe, column strobe and write enable, and an 8-bit data bus. A request carries a flat address and, for a write, one data byte. The sequencer splits the flat address into a row half and a column half. The width of each half comes from a runtime setting. The sequencer then steps the strobes through a fixed order, one step per phase, where a phase lasts `PHASE_CYC` clock cycles so that slow parts meet their timing.

Every command ends with a column-before-row refresh. A refresh can also be requested on its own while the block is idle. Read cycles first pull the data bus to zero and then release it, so a read that nothing answers returns zero rather than stale data. The data bus is brought out as separate output, output-enable and input vectors, and the pad ring joins them.

Top module: `dram_seq`

## Requirements
- R1: While reset is held, rasN, casN and weN are 1 and dqOe is 0. After reset, busy stays 1 through one idle phase and one refresh cycle, done does not pulse for that boot refresh, and requests are taken only once busy has fallen.
- R2: A request is accepted only when halfBits is between 1 and 12. With any other value, reqValid is ignored: busy stays 0 and the strobes stay high.
- R3: With n = halfBits and mask = 2^n - 1, the row is (reqAddr >> n) & mask and is on dramAddr when rasN falls. The column is reqAddr & mask and is on dramAddr when casN falls. dramAddr holds steady while casN is low.
- R4: A write runs these steps in order: bus driven with the byte, weN low, row on dramAddr, rasN low, column on dramAddr, casN low, rasN high, casN high, bus released, weN high. casN is never low with weN low unless dqOe is 1.
- R5: A read runs these steps in order: weN high with the bus driven to 0x00, bus released, row, rasN low, column, casN low, rasN high, casN high. A read of a cell that the module does not answer returns 0x00 on a bus that holds its last value.
- R6: rdData takes the data bus value at the last cycle of the column-strobe-low step with rasN low, and holds it when done pulses.
- R7: A refresh is casN low, then rasN low, then casN high, then rasN high. The two strobes never fall in the same cycle.
- R8: Every accepted read or write is followed by exactly one refresh before done.
- R9: refreshReq while idle starts one refresh followed by a done pulse. reqValid wins if both are high.
- R10: Each step lasts PHASE_CYC cycles. Counting the accepting clock edge as 0, done rises at edge 13·PHASE_CYC for a write, 12·PHASE_CYC for a read and 4·PHASE_CYC for a refresh request.
- R11: busy is 1 from the accepting edge until done. done lasts one cycle, and busy is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, sampled while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Flat byte address |
| reqWdata | input | DATA_W | Write byte |
| halfBits | input | CFG_W | Address bits per row/column half (1..12) |
| refreshReq | input | 1 | Standalone refresh request |
| busy | output | 1 | Command or refresh in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Last read byte |
| dramAddr | output | HALF_W | Multiplexed row/column address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| dqOut | output | DATA_W | Data bus drive value |
| dqOe | output | 1 | Data bus drive enable |
| dqIn | input | DATA_W | Data bus sampled value |

## Verification
A behavioural DRAM model in the bench records the row and column it latched on each strobe fall and counts column-before-row refreshes. For split widths 1, 2 and 3, every address of the configuration is first written and then read back. This separates a correct split from shifted or unmasked ones, because each cell is keyed by the row and column that the bench computes. Width 12 with large addresses, and width 2 with address bits above the used range, test the masking edges. A read of an unwritten cell just after a write tells whether the bus was discharged. Invalid widths 0 and 13, together with simultaneous reqValid and refreshReq, check rejection and priority. Cycle counts to done separate the per-step phase length from an off-by-one in the step counter.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // Strobes from control to datapath, all active high.
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic drive;
    logic zero;
    logic selCol;
    logic load;
    logic capture;
  } strobe_t;

  typedef enum logic [4:0] {
    S_BOOT, S_IDLE,
    S_W_DATA, S_W_WE, S_W_ROW, S_W_RAS, S_W_COL, S_W_CAS, S_W_RRAS, S_W_RCAS, S_W_TRI,
    S_R_ZERO, S_R_TRI, S_R_ROW, S_R_RAS, S_R_COL, S_R_CAS, S_R_RRAS, S_R_RCAS,
    S_F_CAS, S_F_RAS, S_F_RCAS, S_F_REL
  } step_e;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int PHASE_CYC = 2,
  parameter int HALF_W    = 12,
  parameter int CFG_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CFG_W-1:0] halfBits,
  input  logic             refreshReq,
  output strobe_t          strb,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

  step_e             state;
  logic [CNT_W-1:0]  cnt;
  logic              doneArm;
  logic              cfgOk;
  logic              phaseEnd;
  logic              accept;

  assign cfgOk    = (halfBits != '0) && (halfBits <= CFG_W'(HALF_W));
  assign phaseEnd = (cnt == CNT_W'(PHASE_CYC - 1));
  assign accept   = (state == S_IDLE) && reqValid && cfgOk;
  assign busy     = (state != S_IDLE);

  function automatic step_e succ(step_e s);
    case (s)
      S_BOOT:   succ = S_F_CAS;
      S_W_DATA: succ = S_W_WE;
      S_W_WE:   succ = S_W_ROW;
      S_W_ROW:  succ = S_W_RAS;
      S_W_RAS:  succ = S_W_COL;
      S_W_COL:  succ = S_W_CAS;
      S_W_CAS:  succ = S_W_RRAS;
      S_W_RRAS: succ = S_W_RCAS;
      S_W_RCAS: succ = S_W_TRI;
      S_W_TRI:  succ = S_F_CAS;
      S_R_ZERO: succ = S_R_TRI;
      S_R_TRI:  succ = S_R_ROW;
      S_R_ROW:  succ = S_R_RAS;
      S_R_RAS:  succ = S_R_COL;
      S_R_COL:  succ = S_R_CAS;
      S_R_CAS:  succ = S_R_RRAS;
      S_R_RRAS: succ = S_R_RCAS;
      S_R_RCAS: succ = S_F_CAS;
      S_F_CAS:  succ = S_F_RAS;
      S_F_RAS:  succ = S_F_RCAS;
      S_F_RCAS: succ = S_F_REL;
      default:  succ = S_IDLE;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_BOOT;
      cnt     <= '0;
      doneArm <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        cnt <= '0;
        if (accept) begin
          state   <= reqWrite ? S_W_DATA : S_R_ZERO;
          doneArm <= 1'b1;
        end else if (refreshReq) begin
          state   <= S_F_CAS;
          doneArm <= 1'b1;
        end
      end else if (phaseEnd) begin
        cnt   <= '0;
        state <= succ(state);
        if (state == S_F_REL) begin
          done    <= doneArm;
          doneArm <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Strobe decode per step
  always_comb begin
    strb = '0;
    case (state)
      S_W_DATA: begin strb.drive = 1'b1; end
      S_W_WE, S_W_ROW: begin strb.drive = 1'b1; strb.we = 1'b1; end
      S_W_RAS:  begin strb.drive = 1'b1; strb.we = 1'b1; strb.ras = 1'b1; end
      S_W_COL:  begin strb.drive = 1'b1; strb.we = 1'b1; strb.ras = 1'b1; strb.selCol = 1'b1; end
      S_W_CAS:  begin strb.drive = 1'b1; strb.we = 1'b1; strb.ras = 1'b1; strb.cas = 1'b1; strb.selCol = 1'b1; end
      S_W_RRAS: begin strb.drive = 1'b1; strb.we = 1'b1; strb.cas = 1'b1; strb.selCol = 1'b1; end
      S_W_RCAS: begin strb.drive = 1'b1; strb.we = 1'b1; strb.selCol = 1'b1; end
      S_W_TRI:  begin strb.we = 1'b1; strb.selCol = 1'b1; end
      S_R_ZERO: begin strb.drive = 1'b1; strb.zero = 1'b1; end
      S_R_RAS:  begin strb.ras = 1'b1; end
      S_R_COL:  begin strb.ras = 1'b1; strb.selCol = 1'b1; end
      S_R_CAS:  begin strb.ras = 1'b1; strb.cas = 1'b1; strb.selCol = 1'b1; strb.capture = phaseEnd; end
      S_R_RRAS: begin strb.cas = 1'b1; strb.selCol = 1'b1; end
      S_R_RCAS: begin strb.selCol = 1'b1; end
      S_F_CAS:  begin strb.cas = 1'b1; end
      S_F_RAS:  begin strb.cas = 1'b1; strb.ras = 1'b1; end
      S_F_RCAS: begin strb.ras = 1'b1; end
      default:  ;
    endcase
    strb.load = accept;
  end

  a_r2_bad_cfg_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && !cfgOk && !refreshReq) |=> !busy);
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/dram_seq_dp.sv
module dram_seq_dp
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int HALF_W = 12,
  parameter int CFG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CFG_W-1:0]  halfBits,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] rdData,
  output logic [HALF_W-1:0] dramAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [CFG_W-1:0]  bitsQ;
  logic [ADDR_W-1:0] fullMask;
  logic [ADDR_W-1:0] rowFull;
  logic [ADDR_W-1:0] colFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      bitsQ  <= CFG_W'(1);
      rdData <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        bitsQ  <= halfBits;
      end
      if (strb.capture) rdData <= dqIn;
    end
  end

  assign fullMask = (ADDR_W'(1) << bitsQ) - ADDR_W'(1);
  assign rowFull  = (addrQ >> bitsQ) & fullMask;
  assign colFull  = addrQ & fullMask;
  assign dramAddr = strb.selCol ? colFull[HALF_W-1:0] : rowFull[HALF_W-1:0];

  assign rasN  = ~strb.ras;
  assign casN  = ~strb.cas;
  assign weN   = ~strb.we;
  assign dqOe  = strb.drive;
  assign dqOut = strb.zero ? '0 : wdataQ;

  a_r4_we_with_bus: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && !weN) |-> dqOe);
  a_r7_no_joint_fall: assert property (@(posedge clk) disable iff (!rstN)
    !($fell(rasN) && $fell(casN)));
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && $past(!casN)) |-> $stable(dramAddr));
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rstN |=> (rasN && casN && weN && !dqOe));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int PHASE_CYC = 2,
  localparam int HALF_W   = ADDR_W / 2,
  localparam int CFG_W    = $clog2(HALF_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [CFG_W-1:0]  halfBits,
  input  logic              refreshReq,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [HALF_W-1:0] dramAddr,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  input  logic [DATA_W-1:0] dqIn
);

  strobe_t strb;

  dram_seq_ctrl #(.PHASE_CYC(PHASE_CYC), .HALF_W(HALF_W), .CFG_W(CFG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .halfBits(halfBits), .refreshReq(refreshReq),
    .strb(strb), .busy(busy), .done(done)
  );

  dram_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W), .CFG_W(CFG_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .halfBits(halfBits), .dqIn(dqIn), .rdData(rdData), .dramAddr(dramAddr),
    .rasN(rasN), .casN(casN), .weN(weN), .dqOut(dqOut), .dqOe(dqOe)
  );

endmodule

// File: tb/sim_dram_seq.sv
module sim_dram_seq;

  localparam int PERIOD = 10;
  localparam int P      = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [3:0]  halfBits = 4'd1;
  logic        refreshReq = 1'b0;
  logic        busy, done;
  logic [7:0]  rdData;
  logic [11:0] dramAddr;
  logic        rasN, casN, weN, dqOe;
  logic [7:0]  dqOut;
  logic [7:0]  dqIn;

  int compared = 0;
  int mismatched = 0;

  always #(PERIOD/2) clk = ~clk;

  dram_seq #(.ADDR_W(24), .DATA_W(8), .PHASE_CYC(P)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .halfBits(halfBits),
    .refreshReq(refreshReq), .busy(busy), .done(done), .rdData(rdData),
    .dramAddr(dramAddr), .rasN(rasN), .casN(casN), .weN(weN),
    .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  // Behavioural DRAM module with a bus that keeps its last driven value
  logic [7:0] cells [int];
  int   rowL = 0, colL = 0, refreshCnt = 0;
  bit   cbrArm = 0, rdHit = 0;
  logic [7:0] rdVal = '0, busHold = '0;

  always @(negedge rasN) begin
    if (casN) rowL = int'(dramAddr);
    else if (cbrArm) begin refreshCnt++; cbrArm = 0; end
  end

  always @(negedge casN) begin
    if (rasN) cbrArm = 1;
    else begin
      colL = int'(dramAddr);
      if (!weN) begin cells[rowL*4096 + colL] = dqOut; rdHit = 0; end
      else if (cells.exists(rowL*4096 + colL)) begin rdHit = 1; rdVal = cells[rowL*4096 + colL]; end
      else rdHit = 0;
    end
  end

  always @(negedge clk) if (dqOe) busHold <= dqOut;

  assign dqIn = (!casN && !rasN && weN && rdHit) ? rdVal : busHold;

  // Bench reference contents
  logic [7:0] refMem [int];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input bit wr, input int hb, input int addr, input logic [7:0] wd,
                       output logic [7:0] rd, output int lat);
    int r0;
    r0 = refreshCnt;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = 24'(addr); reqWdata = wd; halfBits = 4'(hb);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
    lat = 1;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    rd = rdData;
    chk(busy == 1'b0, "R11 busy low with done", busy, 0);
    chk(refreshCnt == r0 + 1, "R8 refresh per command", refreshCnt - r0, 1);
  endtask

  task automatic access(input bit wr, input int hb, input int addr, input logic [7:0] wd);
    int mask, row, col, lat, key;
    logic [7:0] rd, exp;
    mask = (1 << hb) - 1;
    row = (addr >> hb) & mask;
    col = addr & mask;
    key = row*4096 + col;
    runOp(wr, hb, addr, wd, rd, lat);
    chk(rowL == row, "R3 row split", rowL, row);
    chk(colL == col, "R3 column split", colL, col);
    if (wr) begin
      refMem[key] = wd;
      chk(lat == 13*P + 1, "R10 write latency", lat, 13*P + 1);
    end else begin
      exp = refMem.exists(key) ? refMem[key] : 8'h00;
      chk(rd == exp, "R6 R5 read data", rd, exp);
      chk(lat == 12*P + 1, "R10 read latency", lat, 12*P + 1);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] rd;
    bit sawBusy, sawDone, sawRas;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(rasN && casN && weN && !dqOe, "R1 strobes in reset", {rasN, casN, weN, dqOe}, 4'b1110);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy during boot refresh", busy, 1);
    sawDone = 0;
    for (int i = 0; i < 40 && busy; i++) begin
      @(negedge clk);
      if (done) sawDone = 1;
    end
    chk(busy == 1'b0, "R1 boot completes", busy, 0);
    chk(refreshCnt == 1, "R1 one boot refresh", refreshCnt, 1);
    chk(!sawDone, "R1 no done for boot", sawDone, 0);

    // R5 discharge: unwritten cell after a write reads zero
    access(1'b1, 3, 0, 8'hA5);
    access(1'b0, 3, 9, 8'h00);

    // Sweeps over small split widths
    for (int hb = 1; hb <= 3; hb++) begin
      for (int a = 0; a < (1 << (2*hb)); a++) access(1'b1, hb, a, 8'((a*37 + hb*11 + 5) & 255));
      for (int a = 0; a < (1 << (2*hb)); a++) access(1'b0, hb, a, 8'h00);
    end

    // R3 masking edges
    access(1'b1, 2, 'h35, 8'h3C);
    access(1'b0, 2, 'h05, 8'h00);
    access(1'b1, 12, 'hFFFFFF, 8'hE7);
    access(1'b1, 12, 'hABC123, 8'h19);
    access(1'b0, 12, 'hFFFFFF, 8'h00);
    access(1'b0, 12, 'hABC123, 8'h00);

    // R2 invalid widths
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 24'h3; halfBits = (k == 0) ? 4'd0 : 4'd13;
      sawBusy = 0; sawRas = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (busy) sawBusy = 1;
        if (!rasN || !casN) sawRas = 1;
      end
      reqValid = 1'b0;
      chk(!sawBusy, "R2 bad width not accepted", sawBusy, 0);
      chk(!sawRas, "R2 strobes stay high", sawRas, 0);
    end

    // R9 standalone refresh
    begin
      int r0;
      r0 = refreshCnt;
      @(negedge clk);
      refreshReq = 1'b1;
      @(negedge clk);
      refreshReq = 1'b0;
      lat = 1;
      while (!done && lat < 400) begin @(negedge clk); lat++; end
      chk(lat == 4*P + 1, "R9 R10 refresh latency", lat, 4*P + 1);
      chk(refreshCnt == r0 + 1, "R9 R7 refresh seen", refreshCnt - r0, 1);
      @(negedge clk);
      chk(done == 1'b0, "R11 done one cycle", done, 0);
    end

    // R9 priority: both requests -> write wins
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 24'h2; reqWdata = 8'h77; halfBits = 4'd1;
    refreshReq = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; refreshReq = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    chk(lat == 13*P + 1, "R9 request wins over refresh", lat, 13*P + 1);
    refMem[1*4096 + 0] = 8'h77;
    access(1'b0, 1, 2, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule